// File: doc/BRIEF.md
# Zone Protection Access Checker

This block sits after the translation lookup of a memory management unit and decides whether the current access may proceed. It holds one 32-bit zone protection register with sixteen 2-bit zone codes. The matched translation entry supplies its valid, writable and executable bits and a 4-bit zone index. That index selects one zone code. Depending on the processor mode, the code either leaves the entry's permissions alone, forces the page invalid, or grants write and execute rights.

The effective permissions and an access-fault flag are combinational functions of the current inputs and the stored register. Software-side logic loads the register through a simple write port and can read it back at any time. A write changes decisions from the next clock cycle onward.

Top module: `zone_guard`

## Requirements
- R1: While `rst_n` is low and after reset is released, `cfg_rd_data` reads 0x00000000 until the first write.
- R2: When `cfg_wr_en` is high at a rising clock edge, `cfg_wr_data` is stored and appears on `cfg_rd_data` after that edge. Access decisions in the cycle of the write still use the old contents.
- R3: The code for zone i occupies register bits [31-2i : 30-2i], so zone 0 is the two most significant bits and zone 15 the two least significant.
- R4: In user mode (`user_mode`=1), code 00 drives `eff_valid` low, and every access kind faults whatever `ent_valid` is.
- R5: In user mode, codes 01 and 10 pass `ent_valid`, `ent_write` and `ent_exec` unchanged to the effective outputs.
- R6: In user mode, code 11 drives `eff_write` and `eff_exec` high, while `eff_valid` still follows `ent_valid`.
- R7: In privileged mode (`user_mode`=0), codes 00 and 01 pass the entry's three permission bits unchanged.
- R8: In privileged mode, codes 10 and 11 drive `eff_write` and `eff_exec` high, while `eff_valid` follows `ent_valid`.
- R9: No code ever raises `eff_valid`. An access to an invalid entry faults in every mode and zone.
- R10: `acc_kind` is encoded as 00 read, 01 write, 10 fetch, with 11 treated as read. A read faults only when `eff_valid` is 0. A write also faults when `eff_write` is 0. A fetch also faults when `eff_exec` is 0.
- R11: The effective outputs and `acc_fault` follow changes on the access inputs in the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_data | input | 32 | Value to store in the zone register |
| cfg_rd_data | output | 32 | Current zone register contents |
| ent_valid | input | 1 | Valid bit of the matched entry |
| ent_write | input | 1 | Writable bit of the matched entry |
| ent_exec | input | 1 | Executable bit of the matched entry |
| ent_zone | input | 4 | Zone index of the matched entry |
| user_mode | input | 1 | 1 = user mode, 0 = privileged mode |
| acc_kind | input | 2 | Access kind: 00 read, 01 write, 10 fetch, 11 read |
| eff_valid | output | 1 | Effective valid permission |
| eff_write | output | 1 | Effective writable permission |
| eff_exec | output | 1 | Effective executable permission |
| acc_fault | output | 1 | Access must not proceed |

## Verification
The bench builds the block with its default sixteen zones of two bits each, which matches the register width. With these values every zone position and all four codes can be reached in both modes. Each table vector puts its code into a different zone and loads the complementary code into every other zone. Any field misplacement or swapped code therefore changes the observed fault. A sweep that enables one zone at a time then confirms the bit order from zone 0 at the top end to zone 15 at the bottom.

// File: rtl/zg_pkg.sv
package zg_pkg;

  localparam logic [1:0] KIND_READ  = 2'b00;
  localparam logic [1:0] KIND_WRITE = 2'b01;
  localparam logic [1:0] KIND_FETCH = 2'b10;

  // Page forced invalid: only user mode with an all-zero code.
  function automatic logic zone_kills(input logic user, input logic [1:0] code);
    return user && (code == 2'b00);
  endfunction

  // Write and execute granted regardless of the entry.
  function automatic logic zone_grants(input logic user, input logic [1:0] code);
    return user ? (code == 2'b11) : code[1];
  endfunction

  function automatic logic kind_faults(input logic [1:0] kind, input logic v,
                                       input logic w, input logic x);
    logic f;
    f = !v;
    if (kind == KIND_WRITE) f = f || !w;
    if (kind == KIND_FETCH) f = f || !x;
    return f;
  endfunction

endpackage

// File: rtl/zg_store.sv
module zg_store #(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (wr_en) q <= wr_data;
  end
endmodule

// File: rtl/zg_field_pick.sv
module zg_field_pick #(
  parameter int NUM_ZONES = 16,
  parameter int CODE_W    = 2,
  localparam int REG_W    = NUM_ZONES * CODE_W,
  localparam int ZIDX_W   = $clog2(NUM_ZONES)
) (
  input  logic [REG_W-1:0]  reg_q,
  input  logic [ZIDX_W-1:0] zone,
  output logic [CODE_W-1:0] code
);
  logic [CODE_W-1:0] codes [NUM_ZONES];

  // Zone 0 occupies the most significant field.
  for (genvar g = 0; g < NUM_ZONES; g++) begin : g_field
    assign codes[g] = reg_q[REG_W-1-g*CODE_W -: CODE_W];
  end

  assign code = codes[zone];
endmodule

// File: rtl/zg_decide.sv
module zg_decide
  import zg_pkg::*;
(
  input  logic       user_mode,
  input  logic [1:0] code,
  input  logic       ent_valid,
  input  logic       ent_write,
  input  logic       ent_exec,
  input  logic [1:0] acc_kind,
  output logic       force_off,
  output logic       force_rw,
  output logic       eff_valid,
  output logic       eff_write,
  output logic       eff_exec,
  output logic       acc_fault
);
  always_comb begin
    force_off = zone_kills(user_mode, code);
    force_rw  = zone_grants(user_mode, code);
    eff_valid = ent_valid && !force_off;
    eff_write = ent_write || force_rw;
    eff_exec  = ent_exec  || force_rw;
    acc_fault = kind_faults(acc_kind, eff_valid, eff_write, eff_exec);
  end
endmodule

// File: rtl/zone_guard.sv
module zone_guard #(
  parameter int NUM_ZONES = 16,
  parameter int CODE_W    = 2,
  localparam int REG_W    = NUM_ZONES * CODE_W,
  localparam int ZIDX_W   = $clog2(NUM_ZONES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [REG_W-1:0]  cfg_wr_data,
  output logic [REG_W-1:0]  cfg_rd_data,
  input  logic              ent_valid,
  input  logic              ent_write,
  input  logic              ent_exec,
  input  logic [ZIDX_W-1:0] ent_zone,
  input  logic              user_mode,
  input  logic [1:0]        acc_kind,
  output logic              eff_valid,
  output logic              eff_write,
  output logic              eff_exec,
  output logic              acc_fault
);
  logic [REG_W-1:0]  zone_reg;
  logic [CODE_W-1:0] zone_code;
  logic              force_off;
  logic              force_rw;

  zg_store #(.REG_W(REG_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_data(cfg_wr_data), .q(zone_reg)
  );

  zg_field_pick #(.NUM_ZONES(NUM_ZONES), .CODE_W(CODE_W)) u_pick (
    .reg_q(zone_reg), .zone(ent_zone), .code(zone_code)
  );

  zg_decide u_decide (
    .user_mode(user_mode), .code(zone_code[1:0]),
    .ent_valid(ent_valid), .ent_write(ent_write), .ent_exec(ent_exec),
    .acc_kind(acc_kind), .force_off(force_off), .force_rw(force_rw),
    .eff_valid(eff_valid), .eff_write(eff_write), .eff_exec(eff_exec),
    .acc_fault(acc_fault)
  );

  assign cfg_rd_data = zone_reg;
endmodule

// File: rtl/zg_guard_chk.sv
module zg_guard_chk #(
  parameter int REG_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_wr_en,
  input logic [REG_W-1:0] cfg_wr_data,
  input logic [REG_W-1:0] cfg_rd_data,
  input logic             ent_valid,
  input logic             user_mode,
  input logic [1:0]       acc_kind,
  input logic [1:0]       zone_code,
  input logic             force_off,
  input logic             force_rw,
  input logic             eff_valid,
  input logic             eff_write,
  input logic             eff_exec,
  input logic             acc_fault
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) !rst_n |-> cfg_rd_data == '0);

  // R2
  write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_en |=> cfg_rd_data == $past(cfg_wr_data));

  // R2
  hold_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr_en |=> $stable(cfg_rd_data));

  // R4
  user_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (user_mode && zone_code == 2'b00) |-> (!eff_valid && acc_fault));

  // R6
  user_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (user_mode && zone_code == 2'b11) |-> (eff_write && eff_exec && eff_valid == ent_valid));

  // R8
  priv_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!user_mode && zone_code[1]) |-> (eff_write && eff_exec && eff_valid == ent_valid));

  // R9
  no_valid_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ent_valid |-> (!eff_valid && acc_fault));

  // R10
  fetch_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_kind == 2'b10 && !eff_exec) |-> acc_fault);

  // R10
  store_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_kind == 2'b01 && !eff_write) |-> acc_fault);

  // R10
  read_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_kind[0] == acc_kind[1] && eff_valid) |-> !acc_fault);

  // R4
  kill_grant_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(force_off && force_rw));
endmodule

bind zone_guard zg_guard_chk #(.REG_W(REG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
  .cfg_rd_data(cfg_rd_data), .ent_valid(ent_valid), .user_mode(user_mode),
  .acc_kind(acc_kind), .zone_code(zone_code[1:0]), .force_off(force_off),
  .force_rw(force_rw), .eff_valid(eff_valid), .eff_write(eff_write),
  .eff_exec(eff_exec), .acc_fault(acc_fault)
);

// File: tb/zone_guard_test.sv
module zone_guard_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [31:0] cfg_wr_data = '0;
  logic [31:0] cfg_rd_data;
  logic        ent_valid = 1'b0, ent_write = 1'b0, ent_exec = 1'b0;
  logic [3:0]  ent_zone = '0;
  logic        user_mode = 1'b0;
  logic [1:0]  acc_kind = 2'b00;
  logic        eff_valid, eff_write, eff_exec, acc_fault;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  zone_guard uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_data(cfg_rd_data), .ent_valid(ent_valid), .ent_write(ent_write),
    .ent_exec(ent_exec), .ent_zone(ent_zone), .user_mode(user_mode),
    .acc_kind(acc_kind), .eff_valid(eff_valid), .eff_write(eff_write),
    .eff_exec(eff_exec), .acc_fault(acc_fault)
  );

  // {user, code[1:0], v, w, x, kind[1:0], exp v, exp w, exp x, exp fault}
  localparam logic [11:0] VEC [16] = '{
    {1'b1, 2'b00, 3'b111, 2'b00, 3'b011, 1'b1},  // R4
    {1'b1, 2'b01, 3'b100, 2'b01, 3'b100, 1'b1},  // R5
    {1'b1, 2'b10, 3'b110, 2'b01, 3'b110, 1'b0},  // R5
    {1'b1, 2'b10, 3'b110, 2'b10, 3'b110, 1'b1},  // R5
    {1'b1, 2'b11, 3'b100, 2'b01, 3'b111, 1'b0},  // R6
    {1'b1, 2'b11, 3'b100, 2'b10, 3'b111, 1'b0},  // R6
    {1'b1, 2'b11, 3'b000, 2'b00, 3'b011, 1'b1},  // R6 R9
    {1'b0, 2'b00, 3'b101, 2'b10, 3'b101, 1'b0},  // R7
    {1'b0, 2'b01, 3'b101, 2'b01, 3'b101, 1'b1},  // R7
    {1'b0, 2'b10, 3'b100, 2'b01, 3'b111, 1'b0},  // R8
    {1'b0, 2'b11, 3'b100, 2'b10, 3'b111, 1'b0},  // R8
    {1'b0, 2'b10, 3'b000, 2'b10, 3'b011, 1'b1},  // R8 R9
    {1'b0, 2'b00, 3'b100, 2'b00, 3'b100, 1'b0},  // R7 R10
    {1'b1, 2'b01, 3'b100, 2'b11, 3'b100, 1'b0},  // R10 kind 11 as read
    {1'b1, 2'b00, 3'b000, 2'b00, 3'b000, 1'b1},  // R4 R9
    {1'b0, 2'b01, 3'b011, 2'b00, 3'b011, 1'b1}   // R9
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic [31:0] val);
    @(negedge clk);
    cfg_wr_en = 1'b1;
    cfg_wr_data = val;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  function automatic logic [31:0] fill(input int zone, input logic [1:0] code, input logic [1:0] rest);
    logic [31:0] r = '0;
    for (int z = 0; z < 16; z++)
      r[31-2*z -: 2] = (z == zone) ? code : rest;
    return r;
  endfunction

  initial begin
    #200000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset contents
    #12;
    check("R1 during reset", cfg_rd_data, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", cfg_rd_data, 32'h0);

    // Table walk: code into zone i, complement code into the other zones
    for (int i = 0; i < 16; i++) begin
      logic [11:0] v;
      logic [31:0] rv;
      v = VEC[i];
      rv = fill(i, v[10:9], ~v[10:9]);
      write_reg(rv);
      check("R2 readback", cfg_rd_data, rv);
      user_mode = v[11];
      ent_valid = v[8]; ent_write = v[7]; ent_exec = v[6];
      acc_kind  = v[5:4];
      ent_zone  = 4'(i);
      #1;
      check($sformatf("R4-R10 vec%0d eff", i), {29'd0, eff_valid, eff_write, eff_exec}, {29'd0, v[3:1]});
      check($sformatf("R10 vec%0d fault", i), {31'd0, acc_fault}, {31'd0, v[0]});
    end

    // R3: one zone at a time granted in user mode, others killed
    user_mode = 1'b1; ent_valid = 1'b1; ent_write = 1'b0; ent_exec = 1'b0;
    acc_kind = 2'b10;
    for (int k = 0; k < 16; k++) begin
      write_reg(fill(k, 2'b11, 2'b00));
      for (int z = 0; z < 16; z++) begin
        ent_zone = 4'(z);
        #1;
        check($sformatf("R3 zone%0d sel%0d", k, z), {31'd0, acc_fault}, {31'd0, z != k});
      end
    end

    // R2 / R11: write in flight does not change decisions before the edge
    write_reg(32'h0);
    user_mode = 1'b0; ent_zone = 4'd15; acc_kind = 2'b01;
    ent_valid = 1'b1; ent_write = 1'b0; ent_exec = 1'b0;
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_data = 32'h0000_0002;
    #1;
    check("R2 old value before edge", {31'd0, acc_fault}, 32'd1);
    @(posedge clk);
    #1;
    cfg_wr_en = 1'b0;
    check("R2 new value after edge", {31'd0, acc_fault}, 32'd0);
    check("R2 readback zone15", cfg_rd_data, 32'h0000_0002);

    // R11: input change alone moves the outputs
    acc_kind = 2'b00; ent_valid = 1'b0;
    #1;
    check("R11 combinational fault", {31'd0, acc_fault}, 32'd1);
    ent_valid = 1'b1;
    #1;
    check("R11 combinational clear", {31'd0, acc_fault}, 32'd0);

    // R1: reset again clears contents
    write_reg(32'hFFFF_FFFF);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 reset reclears", cfg_rd_data, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 held after release", cfg_rd_data, 32'h0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule